// File: doc/BRIEF.md
# Translation Lookaside Buffer with Walk Fill

This block keeps a small, fully associative set of recent virtual-to-physical page translations in front of an external page table walker. A lookup carries a 48-bit virtual address, an access kind and the privilege of the requester. When the page number matches a stored entry, the block checks the stored permissions and returns either the physical address or a protection fault in the same cycle, without touching the walker.

On a miss the block holds the request, asks the walker for the page number, and stalls further lookups until the walker answers. A clean walk result that also passes the permission check is installed and used to form the address. Walker faults are passed through unchanged. Walk results may describe 2 MB pages, which then cover a whole aligned range of small page numbers. A flush input, used when the address-space base changes at a context switch, drops every entry marked user-accessible and keeps kernel translations.

Top module: `tlb_walk_cache`

## Requirements
- R1: After reset the buffer holds no valid entry: reqReady is high, walkReqValid is low and the first lookup of any address misses.
- R2: The tag is the virtual address shifted right by 12. An accepted lookup whose page number matches a valid 4 KB entry raises respValid in the same cycle with respFault 0 and respPa = (stored page number << 12) | reqVa[11:0], and no walk is requested.
- R3: Access encoding in reqAccess is 0 read, 1 write, 2 execute (3 behaves as read). A lookup is denied when it writes to an entry without the write bit, executes from an entry without the execute bit, or comes from user mode (reqUser high) to an entry without the user bit. A denied hit answers in the same cycle with respFault 2 and no walk; a denied walk result answers with respFault 2 and is not installed.
- R4: An accepted lookup that misses raises walkReqValid from the next cycle with walkVpn = reqVa[47:12], held until walkRespValid. In the cycle of the walker's answer respValid is high and the result is formed from the walk data; a clean result is installed so a later lookup of the same page hits.
- R5: A walk answered with walkFault nonzero (1 page fault, 2 protection fault) returns that code in respFault and installs nothing, so the same page walks again on its next lookup.
- R6: reqReady is low from the cycle after a missing lookup is accepted through the walk response cycle; a lookup presented meanwhile is not taken.
- R7: Eight entries. An install uses the lowest-index invalid entry; when all are valid it replaces the entry under a round-robin pointer that starts at 0 and advances by one (wrapping) on each such replacement. When two entries match, the lowest index wins.
- R8: flushUser high invalidates at the clock edge every entry whose user bit is set; kernel entries stay valid. A lookup in the same cycle still sees the entries before the flush.
- R9: When flushUser is high in a walk response cycle the response is discarded: no respValid, no install, and walkReqValid stays high so the walk is issued again.
- R10: An entry installed with walkBig high matches on page number bits 35..9 only and forms respPa = {page number bits 39..9, reqVa[20:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup presented |
| reqReady | output | 1 | Lookup can be taken this cycle |
| reqVa | input | 48 | Virtual address of the lookup |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqUser | input | 1 | Requester runs in user mode |
| respValid | output | 1 | Lookup result valid this cycle |
| respPa | output | 52 | Physical address (meaningful when respFault is 0) |
| respFault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| walkReqValid | output | 1 | Walk requested, held until answered |
| walkVpn | output | 36 | Page number to walk |
| walkRespValid | input | 1 | Walker answer valid this cycle |
| walkPpn | input | 40 | Physical page number from the walk |
| walkUser | input | 1 | Walked entry allows user access |
| walkWrite | input | 1 | Walked entry allows writes |
| walkExec | input | 1 | Walked entry allows execution |
| walkBig | input | 1 | Walked entry maps a 2 MB page |
| walkFault | input | 2 | Walker fault: 0 none, 1 page, 2 protection |
| flushUser | input | 1 | Invalidate all user entries |

## Verification
A hit result, its fault code and its address are due combinationally in the very cycle the lookup is accepted, while a miss shows up as walkReqValid one register later and its result lands in the cycle walkRespValid is driven; an installed entry can hit from the cycle after that, and a flush takes effect for the lookup that follows the flush cycle. The bench drives every input at the falling edge, waits 1 ns, and compares all outputs against a behavioural model that applies these same per-cycle due dates, so every cycle is checked at the point its value is due. Its walker answers a fixed number of cycles after it sees a request, and flushes can be placed exactly on that answer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_PROT = 2'd2;

  typedef struct packed {
    logic user;
    logic write;
    logic exec;
  } perm_t;

  typedef struct packed {
    logic capture;
    logic install;
    logic flush;
  } strobe_t;

  function automatic logic permDenied(perm_t p, logic [1:0] acc, logic usr);
    return (acc == ACC_WRITE && !p.write) ||
           (acc == ACC_EXEC && !p.exec) ||
           (usr && !p.user);
  endfunction

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath #(
  parameter int VA_W      = 48,
  parameter int PPN_W     = 40,
  parameter int PAGE_BITS = 12,
  parameter int BIG_BITS  = 9,
  parameter int ENTRIES   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tlb_pkg::strobe_t              str,
  input  logic [VA_W-1:0]               reqVa,
  input  logic [1:0]                    reqAccess,
  input  logic                          reqUser,
  input  logic [PPN_W-1:0]              walkPpn,
  input  tlb_pkg::perm_t                walkPerm,
  input  logic                          walkBig,
  output logic                          lookHit,
  output logic                          lookViol,
  output logic [PPN_W+PAGE_BITS-1:0]    lookPa,
  output logic                          fillViol,
  output logic [PPN_W+PAGE_BITS-1:0]    fillPa,
  output logic [VA_W-PAGE_BITS-1:0]     heldVpn
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PA_W  = PPN_W + PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LOW_W = BIG_BITS + PAGE_BITS;

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] bigQ;
  logic [ENTRIES-1:0] userVec;
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   tagQ  [ENTRIES];
  logic [PPN_W-1:0]   ppnQ  [ENTRIES];
  perm_t              permQ [ENTRIES];
  logic [IDX_W-1:0]   rrPtrQ;

  logic [VA_W-1:0]    heldVaQ;
  logic [1:0]         heldAccQ;
  logic               heldUserQ;

  logic [VPN_W-1:0]   reqVpn;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   victim;
  logic               anyFree;

  function automatic logic [PA_W-1:0] formPa(logic [PPN_W-1:0] ppn, logic big,
                                             logic [VA_W-1:0] va);
    if (big) return {ppn[PPN_W-1:BIG_BITS], va[LOW_W-1:0]};
    return {ppn, va[PAGE_BITS-1:0]};
  endfunction

  assign reqVpn  = reqVa[VA_W-1:PAGE_BITS];
  assign heldVpn = heldVaQ[VA_W-1:PAGE_BITS];

  // Tag compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    logic hiEq;
    logic loEq;
    assign hiEq = tagQ[g][VPN_W-1:BIG_BITS] == reqVpn[VPN_W-1:BIG_BITS];
    assign loEq = tagQ[g][BIG_BITS-1:0] == reqVpn[BIG_BITS-1:0];
    assign matchVec[g] = validQ[g] && hiEq && (bigQ[g] || loEq);
    assign userVec[g]  = permQ[g].user;
  end

  // Lowest matching index wins
  always_comb begin
    lookHit = 1'b0;
    hitIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        lookHit = 1'b1;
        hitIdx  = IDX_W'(i);
      end
    end
  end

  assign lookPa   = formPa(ppnQ[hitIdx], bigQ[hitIdx], reqVa);
  assign lookViol = permDenied(permQ[hitIdx], reqAccess, reqUser);
  assign fillPa   = formPa(walkPpn, walkBig, heldVaQ);
  assign fillViol = permDenied(walkPerm, heldAccQ, heldUserQ);

  // Victim choice: lowest free slot, else the round-robin pointer
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    victim = anyFree ? freeIdx : rrPtrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      rrPtrQ <= '0;
    end else if (str.flush) begin
      validQ <= validQ & ~userVec;
    end else if (str.install) begin
      validQ[victim] <= 1'b1;
      if (!anyFree) begin
        rrPtrQ <= (rrPtrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrPtrQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (str.install) begin
      tagQ[victim]  <= heldVpn;
      ppnQ[victim]  <= walkPpn;
      permQ[victim] <= walkPerm;
      bigQ[victim]  <= walkBig;
    end
    if (str.capture) begin
      heldVaQ   <= reqVa;
      heldAccQ  <= reqAccess;
      heldUserQ <= reqUser;
    end
  end

  // R8
  flush_drops_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> ((validQ & userVec) == '0));

  // R7
  fill_free_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.install && !(&validQ)) |=> ($countones(validQ) == $countones($past(validQ)) + 1));

  // R2
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> (lookPa[PAGE_BITS-1:0] == reqVa[PAGE_BITS-1:0]));

endmodule

// File: rtl/tlb_control.sv
module tlb_control (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             lookHit,
  input  logic             lookViol,
  input  logic             walkRespValid,
  input  logic [1:0]       walkFault,
  input  logic             fillViol,
  input  logic             flushUser,
  output logic             reqReady,
  output logic             respValid,
  output logic [1:0]       respFault,
  output logic             respFromWalk,
  output logic             walkReqValid,
  output tlb_pkg::strobe_t str
);
  import tlb_pkg::*;

  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e stateQ, stateD;

  always_comb begin
    stateD       = stateQ;
    str          = '0;
    str.flush    = flushUser;
    respValid    = 1'b0;
    respFault    = FLT_NONE;
    respFromWalk = 1'b0;
    reqReady     = (stateQ == ST_IDLE);
    walkReqValid = (stateQ == ST_WALK);
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (lookHit) begin
            respValid = 1'b1;
            respFault = lookViol ? FLT_PROT : FLT_NONE;
          end else begin
            str.capture = 1'b1;
            stateD      = ST_WALK;
          end
        end
      end
      default: begin
        if (walkRespValid && !flushUser) begin
          respValid    = 1'b1;
          respFromWalk = 1'b1;
          stateD       = ST_IDLE;
          if (walkFault != FLT_NONE) begin
            respFault = walkFault;
          end else if (fillViol) begin
            respFault = FLT_PROT;
          end else begin
            str.install = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R6
  stall_after_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !respValid) |=> !reqReady);

  // R4
  walk_after_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !respValid) |=> walkReqValid);

  // R5
  fault_no_install_chk: assert property (@(posedge clk) disable iff (!rstN)
    (walkReqValid && walkRespValid && walkFault != FLT_NONE) |-> !str.install);

  // R9
  flush_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (walkReqValid && walkRespValid && flushUser) |=> (walkReqValid && !respValid));

endmodule

// File: rtl/tlb_walk_cache.sv
module tlb_walk_cache #(
  parameter int VA_W      = 48,
  parameter int PPN_W     = 40,
  parameter int PAGE_BITS = 12,
  parameter int BIG_BITS  = 9,
  parameter int ENTRIES   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [VA_W-1:0]            reqVa,
  input  logic [1:0]                 reqAccess,
  input  logic                       reqUser,
  output logic                       respValid,
  output logic [PPN_W+PAGE_BITS-1:0] respPa,
  output logic [1:0]                 respFault,
  output logic                       walkReqValid,
  output logic [VA_W-PAGE_BITS-1:0]  walkVpn,
  input  logic                       walkRespValid,
  input  logic [PPN_W-1:0]           walkPpn,
  input  logic                       walkUser,
  input  logic                       walkWrite,
  input  logic                       walkExec,
  input  logic                       walkBig,
  input  logic [1:0]                 walkFault,
  input  logic                       flushUser
);
  import tlb_pkg::*;

  localparam int PA_W = PPN_W + PAGE_BITS;

  strobe_t         str;
  perm_t           walkPerm;
  logic            lookHit, lookViol, fillViol, respFromWalk;
  logic [PA_W-1:0] lookPa, fillPa;

  assign walkPerm = '{user: walkUser, write: walkWrite, exec: walkExec};

  tlb_control i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lookHit(lookHit),
    .lookViol(lookViol), .walkRespValid(walkRespValid), .walkFault(walkFault),
    .fillViol(fillViol), .flushUser(flushUser), .reqReady(reqReady),
    .respValid(respValid), .respFault(respFault), .respFromWalk(respFromWalk),
    .walkReqValid(walkReqValid), .str(str)
  );

  tlb_datapath #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PAGE_BITS(PAGE_BITS),
    .BIG_BITS(BIG_BITS), .ENTRIES(ENTRIES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .str(str), .reqVa(reqVa), .reqAccess(reqAccess),
    .reqUser(reqUser), .walkPpn(walkPpn), .walkPerm(walkPerm), .walkBig(walkBig),
    .lookHit(lookHit), .lookViol(lookViol), .lookPa(lookPa),
    .fillViol(fillViol), .fillPa(fillPa), .heldVpn(walkVpn)
  );

  assign respPa = respFromWalk ? fillPa : lookPa;

endmodule

// File: tb/test_tlb_walk_cache.sv
module test_tlb_walk_cache;

  localparam int WALK_LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        respValid;
  logic [51:0] respPa;
  logic [1:0]  respFault;
  logic        walkReqValid;
  logic [35:0] walkVpn;
  logic        walkRespValid = 1'b0;
  logic [39:0] walkPpn = '0;
  logic        walkUser = 1'b0, walkWrite = 1'b0, walkExec = 1'b0, walkBig = 1'b0;
  logic [1:0]  walkFault = '0;
  logic        flushUser = 1'b0;

  always #10 clk = ~clk;

  tlb_walk_cache i_tlb_walk_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAccess(reqAccess), .reqUser(reqUser),
    .respValid(respValid), .respPa(respPa), .respFault(respFault),
    .walkReqValid(walkReqValid), .walkVpn(walkVpn), .walkRespValid(walkRespValid),
    .walkPpn(walkPpn), .walkUser(walkUser), .walkWrite(walkWrite),
    .walkExec(walkExec), .walkBig(walkBig), .walkFault(walkFault),
    .flushUser(flushUser)
  );

  int nChk = 0;
  int nFail = 0;
  int wCnt = 0;
  int cyc = 0;
  bit flushOnResp = 0;
  bit done = 0;
  string phaseTag = "R1";

  // reference state
  bit          mValid [8];
  logic [35:0] mTag [8];
  logic [39:0] mPpn [8];
  bit          mU [8], mW [8], mX [8], mBig [8];
  int          mRr = 0;
  bit          mPend = 0;
  logic [47:0] mVa;
  logic [1:0]  mAcc;
  bit          mUser;

  // walker's page table
  function automatic logic [1:0] ptFault(logic [35:0] v);
    if (v[35:32] == 4'hF) return 2'd1;
    if (v[35:32] == 4'hE) return 2'd2;
    return 2'd0;
  endfunction
  function automatic logic [39:0] ptPpn(logic [35:0] v);
    return {4'h3, v ^ 36'h0_0ABC_DEF0};
  endfunction
  function automatic bit ptBig(logic [35:0] v);
    return v[35:32] == 4'hB;
  endfunction

  function automatic bit denied(bit u, bit w, bit x, logic [1:0] acc, bit usr);
    return (acc == 2'd1 && !w) || (acc == 2'd2 && !x) || (usr && !u);
  endfunction

  function automatic logic [51:0] paOf(logic [39:0] ppn, bit big, logic [47:0] va);
    return big ? {ppn[39:9], va[20:0]} : {ppn, va[11:0]};
  endfunction

  function automatic logic [35:0] mkVpn(logic [3:0] hi, int idx, bit u, bit w, bit x);
    return {hi, 24'(idx), 1'b0, x, w, u, 4'b0};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic cycle(input bit rv, input logic [47:0] va, input logic [1:0] acc,
                       input bit usr, input bit fl);
    bit wr, hit, nPend, inst, expRv;
    int hIdx, slot;
    logic [1:0] expF;
    logic [51:0] expPa;
    logic [35:0] wv, mv, rvpn;
    @(negedge clk);
    wr = 0;
    if (walkReqValid) begin
      wCnt++;
      if (wCnt >= WALK_LAT) begin wr = 1; wCnt = 0; end
    end else wCnt = 0;
    if (wr && flushOnResp) fl = 1;
    wv = walkVpn;
    reqValid = rv; reqVa = va; reqAccess = acc; reqUser = usr; flushUser = fl;
    walkRespValid = wr; walkPpn = ptPpn(wv); walkFault = ptFault(wv);
    walkUser = wv[4]; walkWrite = wv[5]; walkExec = wv[6]; walkBig = ptBig(wv);
    #1;
    chk("R6", "reqReady", reqReady, !mPend);
    chk("R4", "walkReqValid", walkReqValid, mPend);
    mv = mVa[47:12];
    if (mPend) chk("R4", "walkVpn", walkVpn, mv);
    expRv = 0; expF = 0; expPa = 0; inst = 0; nPend = mPend;
    if (!mPend && rv) begin
      rvpn = va[47:12];
      hit = 0; hIdx = 0;
      for (int i = 7; i >= 0; i--) begin
        if (mValid[i] && (mBig[i] ? mTag[i][35:9] == rvpn[35:9] : mTag[i] == rvpn)) begin
          hit = 1; hIdx = i;
        end
      end
      if (hit) begin
        expRv = 1;
        expF = denied(mU[hIdx], mW[hIdx], mX[hIdx], acc, usr) ? 2'd2 : 2'd0;
        expPa = paOf(mPpn[hIdx], mBig[hIdx], va);
      end else begin
        nPend = 1; mVa = va; mAcc = acc; mUser = usr;
      end
    end else if (mPend && wr && !fl) begin
      expRv = 1; nPend = 0;
      expPa = paOf(ptPpn(mv), ptBig(mv), mVa);
      if (ptFault(mv) != 0) expF = ptFault(mv);
      else if (denied(mv[4], mv[5], mv[6], mAcc, mUser)) expF = 2'd2;
      else inst = 1;
    end
    chk(phaseTag, "respValid", respValid, expRv);
    if (expRv) chk(phaseTag, "respFault", respFault, expF);
    if (expRv && expF == 0) chk(phaseTag, "respPa", respPa, expPa);
    if (fl) begin
      for (int i = 0; i < 8; i++) if (mU[i]) mValid[i] = 0;
    end else if (inst) begin
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!mValid[i]) slot = i;
      if (slot < 0) begin slot = mRr; mRr = (mRr + 1) % 8; end
      mValid[slot] = 1; mTag[slot] = mv; mPpn[slot] = ptPpn(mv);
      mU[slot] = mv[4]; mW[slot] = mv[5]; mX[slot] = mv[6]; mBig[slot] = ptBig(mv);
    end
    mPend = nPend;
  endtask

  // keeps the request up until the block takes it
  task automatic lookup(logic [35:0] vpn, logic [11:0] off, logic [1:0] acc, bit usr);
    bit taken = 0;
    while (!taken) begin
      taken = !mPend;
      cycle(1, {vpn, off}, acc, usr, 0);
    end
  endtask

  task automatic settle();
    cycle(0, '0, 0, 0, 0);
    while (mPend) cycle(0, '0, 0, 0, 0);
  endtask

  task automatic flushNow();
    cycle(0, '0, 0, 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL R6 watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [35:0] kA, uB, kC, pf, prf, bg, uD, kE;
    for (int i = 0; i < 8; i++) mValid[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    phaseTag = "R1";
    cycle(0, '0, 0, 0, 0);
    kA = mkVpn(4'h0, 1, 0, 1, 1);
    lookup(kA, 12'h123, 0, 0);
    settle();

    // R2: hits on various offsets and kinds
    phaseTag = "R2";
    lookup(kA, 12'hFFF, 0, 0);
    lookup(kA, 12'h000, 1, 0);
    lookup(kA, 12'h7A5, 2, 0);
    settle();

    // R3: permission rule on hits and on walk results
    phaseTag = "R3";
    uB = mkVpn(4'h1, 2, 1, 0, 0);
    lookup(uB, 12'h010, 0, 1);
    lookup(uB, 12'h020, 1, 1);
    lookup(uB, 12'h030, 2, 1);
    lookup(kA, 12'h040, 0, 1);
    lookup(uB, 12'h050, 3, 0);
    kC = mkVpn(4'h2, 3, 0, 0, 1);
    lookup(kC, 12'h060, 1, 0);
    lookup(kC, 12'h070, 0, 0);
    settle();

    // R5: walker faults pass through, nothing kept
    phaseTag = "R5";
    pf  = mkVpn(4'hF, 4, 1, 1, 1);
    prf = mkVpn(4'hE, 5, 1, 1, 1);
    lookup(pf, 12'h100, 0, 0);
    lookup(pf, 12'h100, 0, 0);
    lookup(prf, 12'h200, 0, 1);
    lookup(prf, 12'h200, 0, 1);
    settle();

    // R7: fill past capacity, then revisit
    phaseTag = "R7";
    for (int i = 0; i < 12; i++) lookup(mkVpn(4'h3, 16 + i, i % 2, 1, 0), 12'(i), 0, 0);
    for (int i = 0; i < 12; i++) lookup(mkVpn(4'h3, 16 + i, i % 2, 1, 0), 12'(i + 5), 1, 0);
    settle();

    // R8: flush keeps kernel, drops user
    phaseTag = "R8";
    uD = mkVpn(4'h4, 6, 1, 1, 1);
    kE = mkVpn(4'h4, 7, 0, 1, 1);
    lookup(uD, 12'h300, 0, 1);
    lookup(kE, 12'h300, 0, 0);
    settle();
    cycle(1, {uD, 12'h301}, 0, 1, 1);
    lookup(kE, 12'h302, 0, 0);
    lookup(uD, 12'h303, 0, 1);
    settle();

    // R9: flush on the walker's answer discards it
    phaseTag = "R9";
    flushOnResp = 1;
    lookup(mkVpn(4'h5, 8, 0, 1, 1), 12'h400, 0, 0);
    repeat (WALK_LAT + 1) cycle(0, '0, 0, 0, 0);
    flushOnResp = 0;
    settle();

    // R10: 2 MB page covers its neighbours
    phaseTag = "R10";
    bg = mkVpn(4'hB, 9, 1, 1, 0);
    lookup(bg, 12'h456, 0, 1);
    lookup({bg[35:9], 9'h1FF}, 12'hABC, 1, 1);
    lookup({bg[35:9], 9'h000}, 12'h001, 2, 1);
    lookup({bg[35:9] + 27'd1, 9'h000}, 12'h001, 0, 1);
    settle();

    // R6: mixed traffic with back-to-back requests and stray flushes
    phaseTag = "R6";
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 19);
      logic [3:0] hi = (sel < 2) ? 4'hB : (sel == 2) ? 4'hF : 4'h6;
      logic [35:0] v = mkVpn(hi, $urandom_range(0, 11), $urandom_range(0, 1),
                             $urandom_range(0, 1), $urandom_range(0, 1));
      if (hi == 4'hB) v[8:0] = 9'($urandom);
      if ($urandom_range(0, 15) == 0) cycle($urandom_range(0, 1), {v, 12'h0}, 0, 0, 1);
      else cycle(1, {v, 12'($urandom)}, 2'($urandom_range(0, 3)), $urandom_range(0, 1), 0);
    end
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule